// File: doc/BRIEF.md
# Dual-Mode Down-Counting Timer with Capture and Auto-Reload

This block is a 16-bit down-counter paired with a 16-bit companion register. The counter moves once for each instruction-rate tick while the run input is high. A single mode input decides what the register is for.

In capture mode, the timer pin is synchronized, and a selected edge on it (rising or falling) copies the live count into the register. This lets software measure periods or time events. In auto-reload mode, the register is the reload source. Each underflow reloads the counter from the register and inverts the pin output. Counting carries on without a pause. The pin output leaves reset high. If the counter first holds the on time and the register holds the off time, and software rewrites the register on each underflow interrupt, the pin becomes a software-driven PWM waveform.

Two sticky flags record underflows and captures. Software clears each one by writing 1 to it. Each flag has its own interrupt enable.

Top module: `dmt_timer`

## Requirements
- R1: While `rst` is high, and after it falls, the counter and the register read 0, `pin_o` reads 1, both flags read 0 and `irq_o` reads 0.
- R2: When `run_i` and `tick_i` are both high and no counter write happens, a nonzero count drops by exactly 1 at the next clock edge. When `run_i` or `tick_i` is low, the count holds.
- R3: In capture mode (`mode_i` = 0), the selected edge on `pin_i` copies the count into the register at the third clock edge after `pin_i` changes, and sets the capture flag. `edge_sel_i` = 1 selects rising edges and 0 selects falling edges. The other edge has no effect.
- R4: If a capture and a register write fall on the same clock edge, the captured count is stored and the write data is dropped.
- R5: In auto-reload mode (`mode_i` = 1), a counting step from 0 loads the register value into the counter, inverts `pin_o` and sets the underflow flag. The next tick keeps counting down from the reloaded value.
- R6: In capture mode, a counting step from 0 wraps the counter to 0xFFFF and sets the underflow flag, and `pin_o` does not change.
- R7: Each flag stays set until a 1 is written to its clear bit (`flag_clr_i` bit 0 for underflow, bit 1 for capture). If a set and a clear arrive on the same edge, the flag stays set.
- R8: `irq_o` is high exactly when at least one flag is set and its enable (`uf_irq_en_i` or `cap_irq_en_i`) is high.
- R9: A counter write loads `tmr_wdata_i` and takes priority over counting and underflow on the same edge. In that case no underflow is recorded.
- R10: In auto-reload mode, edges on `pin_i` neither change the register nor set the capture flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Instruction-rate count enable |
| run_i | input | 1 | Counter run bit |
| mode_i | input | 1 | 0 = capture, 1 = auto-reload |
| edge_sel_i | input | 1 | Capture edge: 1 = rising, 0 = falling |
| pin_i | input | 1 | Timer pin input (asynchronous) |
| pin_o | output | 1 | Timer pin output (PWM in auto-reload mode) |
| tmr_wr_i | input | 1 | Counter write strobe |
| tmr_wdata_i | input | 16 | Counter write data |
| reg_wr_i | input | 1 | Companion register write strobe |
| reg_wdata_i | input | 16 | Companion register write data |
| flag_clr_i | input | 2 | Write-1-to-clear: bit 0 underflow, bit 1 capture |
| uf_irq_en_i | input | 1 | Underflow interrupt enable |
| cap_irq_en_i | input | 1 | Capture interrupt enable |
| tmr_o | output | 16 | Current count |
| reg_o | output | 16 | Companion register |
| uf_flag_o | output | 1 | Sticky underflow flag |
| cap_flag_o | output | 1 | Sticky capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets these corner cases:

- **Counting step from 0 in each mode.** A design that confused the two modes would wrap when it should reload, or toggle the pin while in capture mode.
- **Capture landing on a register write.** A wrong priority would leave the write data in the register instead of the count.
- **Capture polarity and the three-edge latency.** An off-by-one in the synchronizer would update the register one cycle early or late. A wrong edge detect would also capture on the unselected edge.
- **Clear coinciding with a new event, and a counter write coinciding with an underflow.** A faulty design would lose a flag in the first case, or record a spurious underflow in the second.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    parameter int unsigned DMT_W      = 16;
    parameter int unsigned DMT_SYNC_N = 2;

    typedef enum logic {
        MODE_CAPTURE = 1'b0,
        MODE_RELOAD  = 1'b1
    } dmt_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } dmt_edge_s;

    localparam int unsigned FLG_UF  = 0;
    localparam int unsigned FLG_CAP = 1;
    localparam int unsigned FLG_N   = 2;

    function automatic logic dmt_trigger(input dmt_edge_s e, input logic rise_sel);
        return rise_sel ? e.rise : e.fall;
    endfunction

endpackage

// File: rtl/dmt_edge_sync.sv
module dmt_edge_sync
    import dmt_pkg::*;
#(
    parameter int unsigned STAGES = DMT_SYNC_N
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      async_i,
    output dmt_edge_s edge_o
);
    localparam int unsigned CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    generate
        for (genvar i = 0; i < CHAIN; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_comb begin
        edge_o.rise = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
        edge_o.fall = ~chain_q[CHAIN-2] & chain_q[CHAIN-1];
    end
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter
    import dmt_pkg::*;
#(
    parameter int unsigned W = DMT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         step_i,
    input  logic         reload_i,
    input  logic [W-1:0] reload_val_i,
    output logic [W-1:0] cnt_o,
    output logic         uflow_o
);
    logic [W-1:0] cnt_q;
    logic         at_zero;

    assign at_zero = (cnt_q == '0);
    assign uflow_o = step_i && !wr_i && at_zero;
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_i) begin
            cnt_q <= wdata_i;
        end else if (step_i) begin
            if (at_zero) cnt_q <= reload_i ? reload_val_i : '1;
            else         cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/dmt_flag.sv
module dmt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/dmt_timer.sv
module dmt_timer
    import dmt_pkg::*;
#(
    parameter int unsigned W = DMT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         run_i,
    input  logic         mode_i,
    input  logic         edge_sel_i,
    input  logic         pin_i,
    output logic         pin_o,
    input  logic         tmr_wr_i,
    input  logic [W-1:0] tmr_wdata_i,
    input  logic         reg_wr_i,
    input  logic [W-1:0] reg_wdata_i,
    input  logic [1:0]   flag_clr_i,
    input  logic         uf_irq_en_i,
    input  logic         cap_irq_en_i,
    output logic [W-1:0] tmr_o,
    output logic [W-1:0] reg_o,
    output logic         uf_flag_o,
    output logic         cap_flag_o,
    output logic         irq_o
);
    dmt_mode_e    mode;
    dmt_edge_s    pin_edge;
    logic         cap_evt;
    logic         uf_evt;
    logic [W-1:0] reg_q;
    logic         pin_q;
    logic [FLG_N-1:0] flg_set;
    logic [FLG_N-1:0] flg_q;
    logic [FLG_N-1:0] flg_en;

    assign mode = dmt_mode_e'(mode_i);

    dmt_edge_sync #(.STAGES(DMT_SYNC_N)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i(pin_i),
        .edge_o (pin_edge)
    );

    assign cap_evt = (mode == MODE_CAPTURE) && dmt_trigger(pin_edge, edge_sel_i);

    dmt_counter #(.W(W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .wr_i        (tmr_wr_i),
        .wdata_i     (tmr_wdata_i),
        .step_i      (run_i && tick_i),
        .reload_i    (mode == MODE_RELOAD),
        .reload_val_i(reg_q),
        .cnt_o       (tmr_o),
        .uflow_o     (uf_evt)
    );

    // companion register: capture has priority over a software write
    always_ff @(posedge clk) begin
        if (rst)           reg_q <= '0;
        else if (cap_evt)  reg_q <= tmr_o;
        else if (reg_wr_i) reg_q <= reg_wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst)                                pin_q <= 1'b1;
        else if (uf_evt && mode == MODE_RELOAD) pin_q <= ~pin_q;
    end

    assign flg_set[FLG_UF]  = uf_evt;
    assign flg_set[FLG_CAP] = cap_evt;
    assign flg_en[FLG_UF]   = uf_irq_en_i;
    assign flg_en[FLG_CAP]  = cap_irq_en_i;

    generate
        for (genvar f = 0; f < FLG_N; f++) begin : g_flag
            dmt_flag u_flag (
                .clk   (clk),
                .rst   (rst),
                .set_i (flg_set[f]),
                .clr_i (flag_clr_i[f]),
                .flag_o(flg_q[f])
            );
        end
    endgenerate

    assign reg_o      = reg_q;
    assign pin_o      = pin_q;
    assign uf_flag_o  = flg_q[FLG_UF];
    assign cap_flag_o = flg_q[FLG_CAP];
    assign irq_o      = |(flg_q & flg_en);
endmodule

// File: rtl/dmt_timer_chk.sv
module dmt_timer_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         tick_i,
    input logic         run_i,
    input logic         mode_i,
    input logic         tmr_wr_i,
    input logic [W-1:0] tmr_wdata_i,
    input logic [1:0]   flag_clr_i,
    input logic         pin_o,
    input logic [W-1:0] tmr_o,
    input logic [W-1:0] reg_o,
    input logic         uf_flag_o,
    input logic         cap_flag_o
);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tmr_wr_i && !(run_i && tick_i)) |=> (tmr_o == $past(tmr_o)));

    p_dec_r2: assert property (@(posedge clk) disable iff (rst)
        (!tmr_wr_i && run_i && tick_i && tmr_o != '0) |=> (tmr_o == $past(tmr_o) - 1'b1));

    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_i && !tmr_wr_i && run_i && tick_i && tmr_o == '0)
        |=> (tmr_o == $past(reg_o) && pin_o != $past(pin_o) && uf_flag_o));

    p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && !tmr_wr_i && run_i && tick_i && tmr_o == '0)
        |=> (tmr_o == '1 && uf_flag_o));

    p_pin_r6: assert property (@(posedge clk) disable iff (rst)
        !mode_i |=> $stable(pin_o));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (cap_flag_o && !flag_clr_i[1]) |=> cap_flag_o);

    p_write_r9: assert property (@(posedge clk) disable iff (rst)
        tmr_wr_i |=> (tmr_o == $past(tmr_wdata_i)));
endmodule

bind dmt_timer dmt_timer_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .run_i      (run_i),
    .mode_i     (mode_i),
    .tmr_wr_i   (tmr_wr_i),
    .tmr_wdata_i(tmr_wdata_i),
    .flag_clr_i (flag_clr_i),
    .pin_o      (pin_o),
    .tmr_o      (tmr_o),
    .reg_o      (reg_o),
    .uf_flag_o  (uf_flag_o),
    .cap_flag_o (cap_flag_o)
);

// File: tb/dmt_timer_tb_top.sv
module dmt_timer_tb_top;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_i = 0, run_i = 0, mode_i = 0, edge_sel_i = 1, pin_i = 0;
    logic tmr_wr_i = 0, reg_wr_i = 0, uf_irq_en_i = 0, cap_irq_en_i = 0;
    logic [W-1:0] tmr_wdata_i = '0, reg_wdata_i = '0;
    logic [1:0] flag_clr_i = '0;
    logic pin_o, uf_flag_o, cap_flag_o, irq_o;
    logic [W-1:0] tmr_o, reg_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dmt_timer dut_i (
        .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(run_i), .mode_i(mode_i),
        .edge_sel_i(edge_sel_i), .pin_i(pin_i), .pin_o(pin_o),
        .tmr_wr_i(tmr_wr_i), .tmr_wdata_i(tmr_wdata_i),
        .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
        .flag_clr_i(flag_clr_i), .uf_irq_en_i(uf_irq_en_i), .cap_irq_en_i(cap_irq_en_i),
        .tmr_o(tmr_o), .reg_o(reg_o), .uf_flag_o(uf_flag_o),
        .cap_flag_o(cap_flag_o), .irq_o(irq_o)
    );

    // ---------------- reference model ----------------
    logic m_s1, m_s2, m_s3, m_pin, m_uf, m_cf;
    logic [W-1:0] m_tmr, m_reg;
    logic e_cap, e_uf;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
            m_tmr <= '0; m_reg <= '0; m_pin <= 1'b1; m_uf <= 0; m_cf <= 0;
        end else begin
            e_cap = !mode_i && (edge_sel_i ? (m_s2 && !m_s3) : (!m_s2 && m_s3));
            e_uf  = !tmr_wr_i && run_i && tick_i && (m_tmr == '0);
            m_s1 <= pin_i; m_s2 <= m_s1; m_s3 <= m_s2;
            if (tmr_wr_i) m_tmr <= tmr_wdata_i;
            else if (run_i && tick_i) m_tmr <= (m_tmr == '0) ? (mode_i ? m_reg : '1) : m_tmr - 1'b1;
            if (e_cap) m_reg <= m_tmr;
            else if (reg_wr_i) m_reg <= reg_wdata_i;
            if (mode_i && e_uf) m_pin <= ~m_pin;
            if (e_uf) m_uf <= 1'b1; else if (flag_clr_i[0]) m_uf <= 1'b0;
            if (e_cap) m_cf <= 1'b1; else if (flag_clr_i[1]) m_cf <= 1'b0;
        end
    end

    function automatic logic exp_irq(logic uf, logic cf, logic ue, logic ce);
        return (uf && ue) || (cf && ce);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk(input string req, input longint act, input longint exp);
        check(act == exp, req, act, exp);
    endtask

    // advance n edges; inputs then changed 1 ns after the last edge
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic look;
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        step(3);
        look();
        chk("R1 tmr in reset", tmr_o, 0);
        chk("R1 pin in reset", pin_o, 1);
        rst = 0;
        step(1); look();
        chk("R1 reg after reset", reg_o, 0);
        chk("R1 flags after reset", {uf_flag_o, cap_flag_o, irq_o}, 0);

        // R9 write, R2 count and hold
        step(0); tmr_wr_i = 1; tmr_wdata_i = 16'd5;
        step(1); tmr_wr_i = 0; look();
        chk("R9 counter write", tmr_o, 5);
        step(0); run_i = 1; tick_i = 1;
        step(3); look();
        chk("R2 three ticks", tmr_o, 2);
        step(0); tick_i = 0;
        step(2); look();
        chk("R2 hold without tick", tmr_o, 2);

        // R9 write beats underflow
        step(0); tmr_wr_i = 1; tmr_wdata_i = 0;
        step(1); tick_i = 1; tmr_wdata_i = 16'h0040; look();
        step(1); tmr_wr_i = 0; tick_i = 0; look();
        chk("R9 write over underflow tmr", tmr_o, 16'h0040);
        chk("R9 no underflow flag", uf_flag_o, 0);

        // R6 wrap in capture mode
        step(0); tmr_wr_i = 1; tmr_wdata_i = 0;
        step(1); tmr_wr_i = 0; tick_i = 1;
        step(1); tick_i = 0; look();
        chk("R6 wrap to all ones", tmr_o, 16'hFFFF);
        chk("R6 pin unchanged", pin_o, 1);
        chk("R6 underflow flag", uf_flag_o, 1);

        // R8 irq enable, R7 clear
        step(0); uf_irq_en_i = 1; look();
        chk("R8 irq with enabled flag", irq_o, 1);
        step(0); flag_clr_i = 2'b01;
        step(1); flag_clr_i = 0; look();
        chk("R7 write-1 clears flag", uf_flag_o, 0);
        chk("R8 irq drops", irq_o, 0);

        // R3 capture: falling selected, rising edge ignored
        run_i = 0;
        step(0); tmr_wr_i = 1; tmr_wdata_i = 16'd100; edge_sel_i = 0;
        step(1); tmr_wr_i = 0; pin_i = 1;
        step(4); look();
        chk("R3 unselected edge ignored", reg_o, 0);
        chk("R3 unselected edge no flag", cap_flag_o, 0);
        step(0); pin_i = 0;
        step(2); look();
        chk("R3 not before third edge", reg_o, 0);
        step(1); look();
        chk("R3 falling capture value", reg_o, 100);
        chk("R3 capture flag", cap_flag_o, 1);

        // R4 capture beats write; rising selected
        step(0); edge_sel_i = 1; tmr_wr_i = 1; tmr_wdata_i = 16'd77;
        step(1); tmr_wr_i = 0; pin_i = 1;
        step(2); reg_wr_i = 1; reg_wdata_i = 16'hBEEF;
        step(1); reg_wr_i = 0; look();
        chk("R4 capture wins over write", reg_o, 77);

        // R7 set wins over clear: set up a pending capture at the clear edge
        step(0); pin_i = 0; edge_sel_i = 0;
        step(2); flag_clr_i = 2'b10;
        step(1); flag_clr_i = 0; look();
        chk("R7 set wins over clear", cap_flag_o, 1);
        step(0); flag_clr_i = 2'b10;
        step(1); flag_clr_i = 0; look();
        chk("R7 clear after", cap_flag_o, 0);

        // R5 reload mode PWM
        step(0); mode_i = 1; reg_wr_i = 1; reg_wdata_i = 16'd3; tmr_wr_i = 1; tmr_wdata_i = 16'd1;
        step(1); reg_wr_i = 0; tmr_wr_i = 0; run_i = 1; tick_i = 1;
        step(2); look();
        chk("R5 reload from register", tmr_o, 3);
        chk("R5 pin toggled", pin_o, 0);
        chk("R5 underflow flag", uf_flag_o, 1);
        step(1); look();
        chk("R5 keeps counting", tmr_o, 2);

        // R10 pin edges ignored in reload mode
        step(0); tick_i = 0; edge_sel_i = 1; pin_i = 1;
        step(5); look();
        chk("R10 reg untouched", reg_o, 3);
        chk("R10 no capture flag", cap_flag_o, 0);

        // random phase against the model
        begin
            int seed_val;
            seed_val = $urandom(32'h5A17);
        end
        for (int i = 0; i < 4000; i++) begin
            step(0);
            tick_i       = ($urandom % 4) != 0;
            run_i        = ($urandom % 8) != 0;
            mode_i       = (i / 500) % 2 == 1;
            if (($urandom % 40) == 0) edge_sel_i = ~edge_sel_i;
            pin_i        = ($urandom % 6) == 0 ? ~pin_i : pin_i;
            tmr_wr_i     = ($urandom % 30) == 0;
            tmr_wdata_i  = W'($urandom % 12);
            reg_wr_i     = ($urandom % 10) == 0;
            reg_wdata_i  = W'($urandom % 10);
            flag_clr_i   = 2'(($urandom % 8) == 0 ? $urandom : 0);
            uf_irq_en_i  = $urandom;
            cap_irq_en_i = $urandom;
            @(posedge clk);
            @(negedge clk);
            chk("R2 model count", tmr_o, m_tmr);
            chk("R3 model register", reg_o, m_reg);
            chk("R5 model pin", pin_o, m_pin);
            chk("R7 model flags", {uf_flag_o, cap_flag_o}, {m_uf, m_cf});
            chk("R8 model irq", irq_o, exp_irq(m_uf, m_cf, uf_irq_en_i, cap_irq_en_i));
        end

        finish_run();
    end
endmodule